// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

The dispatcher sits between instruction fetch and the functional units of a wide-issue processor. It accepts one fixed-size fetch packet of eight 32-bit instruction words. It cuts that packet into variable-length execute packets and issues one execute packet per clock to eight issue lanes.

Bit 0 of every instruction word is a chaining flag. When the flag is 1, the next word in program order belongs to the same execute packet. When it is 0, the execute packet ends at that word and the next word issues in the following cycle. One fetch packet therefore takes between one and eight issue cycles.

The block holds the current fetch packet. It asks for the next packet in the same cycle that the final execute packet of the current one issues, so back-to-back packets flow without a bubble. A stall input freezes issue.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: After reset, `issue_valid` is all zero, `issue_count` is 0, and `fetch_ready` is 1.
- R2: Starting at the current position, an execute packet takes consecutive words for as long as the word's bit 0 is 1. It ends at the first word whose bit 0 is 0.
- R3: Word 7, the last in the fetch packet, always ends the execute packet, even if its bit 0 is 1.
- R4: Lane j of `issue_instr` (bits 32*j+31 down to 32*j) carries the j-th word of the execute packet, and `issue_valid[j]` is 1 for it. Lanes beyond the packet length have valid 0 and all-zero data.
- R5: `issue_count` equals the number of valid lanes. It lies between 1 and 8 while an execute packet is shown, and is 0 when idle.
- R6: Execute packets of one fetch packet appear on the outputs one per clock, in program order. Each appears on the clock edge after the one that selected it.
- R7: `fetch_ready` is 1 when no packet is held, or when stall is 0 and the final execute packet of the held packet issues this cycle. A packet offered with `fetch_valid` is taken on that edge, and its first execute packet issues on the next edge.
- R8: While stall is 1 and a packet is held, the outputs and the issue position stay unchanged and no new fetch packet is taken.
- R9: When no packet is held and stall is 0, the next edge shows an idle output (no valid lane, count 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch packet offered |
| fetch_data | input | 256 | Eight instruction words, word 0 in bits 31:0 |
| fetch_ready | output | 1 | Dispatcher takes the offered packet on this edge |
| stall | input | 1 | Freeze issue |
| issue_valid | output | 8 | Per-lane valid flags |
| issue_instr | output | 256 | Per-lane instruction words |
| issue_count | output | 4 | Instructions in the shown execute packet |

## Verification
The hardest situation to reach is a stall that arrives exactly in the cycle where the final execute packet would issue. In that cycle the handshake must drop while the held packet stays put. A second hard case is a fetch packet whose word 7 still has its chain flag set.

Random stimulus reaches both: stall is raised about a quarter of the time, and packets are drawn with all-chained, all-broken or mixed flags. Directed sequences also feed an all-chained packet, an all-broken packet with `fetch_valid` held high, and a stall burst in the middle of a packet.

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  parameter int PBIT  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [SLOTS*IW-1:0]    fetch_data,
  output logic                   fetch_ready,
  input  logic                   stall,
  output logic [SLOTS-1:0]       issue_valid,
  output logic [SLOTS*IW-1:0]    issue_instr,
  output logic [$clog2(SLOTS+1)-1:0] issue_count
);
  localparam int PW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS+1);

  logic [SLOTS*IW-1:0] pkt;
  logic                have;
  logic [PW-1:0]       pos;
  logic [CW-1:0]       len;
  logic                last, issue, load;
  logic [SLOTS-1:0]    nx_valid;
  logic [SLOTS*IW-1:0] nx_instr;

  always_comb begin
    logic done;
    done = 1'b0;
    len  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i >= int'(pos) && !done) begin
        len = len + 1'b1;
        if (!pkt[i*IW+PBIT] || i == SLOTS-1) done = 1'b1;
      end
    end
  end

  assign last        = (int'(pos) + int'(len)) == SLOTS;
  assign issue       = have && !stall;
  assign fetch_ready = !have || (issue && last);
  assign load        = fetch_valid && fetch_ready;

  always_comb begin
    nx_valid = '0;
    nx_instr = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (j < int'(len)) begin
        nx_valid[j]           = 1'b1;
        nx_instr[j*IW +: IW]  = pkt[(int'(pos)+j)*IW +: IW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt         <= '0;
      have        <= 1'b0;
      pos         <= '0;
      issue_valid <= '0;
      issue_instr <= '0;
      issue_count <= '0;
    end else begin
      if (issue) begin
        issue_valid <= nx_valid;
        issue_instr <= nx_instr;
        issue_count <= len;
      end else if (!stall) begin
        issue_valid <= '0;
        issue_instr <= '0;
        issue_count <= '0;
      end
      if (load) begin
        pkt  <= fetch_data;
        pos  <= '0;
        have <= 1'b1;
      end else if (issue) begin
        if (last) have <= 1'b0;
        else      pos  <= pos + PW'(len);
      end
    end
  end
endmodule

// File: rtl/vliw_ep_dispatch_chk.sv
module vliw_ep_dispatch_chk #(
  parameter int SLOTS = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             have,
  input logic             fetch_ready,
  input logic [SLOTS-1:0] issue_valid,
  input logic [CW-1:0]    issue_count
);
  AST_COUNT_MATCHES_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_count) == $countones(issue_valid)); // R5
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid & (issue_valid + 1'b1)) == '0); // R4
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !fetch_ready) |=> $stable(issue_valid) && $stable(issue_count)); // R8
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !have |-> fetch_ready); // R7
  AST_IDLE_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!have && !stall) |=> issue_count == '0); // R9
endmodule

bind vliw_ep_dispatch vliw_ep_dispatch_chk #(.SLOTS(SLOTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .have(have),
  .fetch_ready(fetch_ready), .issue_valid(issue_valid), .issue_count(issue_count));

// File: tb/tb_vliw_ep_dispatch.sv
`timescale 1ns/1ps
module tb_vliw_ep_dispatch;
  logic         clk = 0, rst_n = 0, fetch_valid = 0, stall = 0;
  logic [255:0] fetch_data = '0;
  logic         fetch_ready;
  logic [7:0]   issue_valid;
  logic [255:0] issue_instr;
  logic [3:0]   issue_count;

  vliw_ep_dispatch dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [255:0] m_pkt = '0;
  bit           m_have = 0;
  int           m_pos = 0;
  logic [7:0]   e_valid = '0;
  logic [255:0] e_instr = '0;
  int           e_cnt = 0;
  string        kind = "R1";

  function automatic int ep_len(logic [255:0] p, int s);
    for (int i = s; i < 8; i++)
      if (!p[i*32] || i == 7) return i - s + 1;
    return 0;
  endfunction

  function automatic logic [255:0] gen_pkt(int mode);
    logic [255:0] p;
    for (int i = 0; i < 8; i++) begin
      p[i*32 +: 32] = $urandom;
      if (mode == 1) p[i*32] = 1'b1;
      else if (mode == 2) p[i*32] = 1'b0;
      else p[i*32] = ($urandom % 3) != 0;
    end
    return p;
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit fv, int mode, bit st);
    int len;
    bit er;
    @(negedge clk);
    check(kind, {248'd0, issue_valid}, {248'd0, e_valid});
    check(kind, issue_instr, e_instr);
    check("R5", {252'd0, issue_count}, 256'(e_cnt));
    fetch_valid = fv;
    fetch_data  = gen_pkt(mode);
    stall       = st;
    #1;
    len = m_have ? ep_len(m_pkt, m_pos) : 0;
    er  = !m_have || (!st && (m_pos + len == 8));
    check("R7", {255'd0, fetch_ready}, {255'd0, er});
    if (m_have && st) kind = "R8";
    else if (!m_have && !st) begin
      kind = "R9"; e_valid = '0; e_instr = '0; e_cnt = 0;
    end else if (m_have) begin
      if (m_pos + len == 8 && m_pkt[255-31]) kind = "R3";
      else if (m_pos > 0) kind = "R6";
      else kind = "R2";
      e_valid = '0; e_instr = '0; e_cnt = len;
      for (int j = 0; j < len; j++) begin
        e_valid[j] = 1'b1;
        e_instr[j*32 +: 32] = m_pkt[(m_pos+j)*32 +: 32];
      end
    end
    if (fv && er) begin
      m_pkt = fetch_data; m_pos = 0; m_have = 1;
    end else if (m_have && !st) begin
      if (m_pos + len == 8) m_have = 0;
      else m_pos = m_pos + len;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1", {248'd0, issue_valid}, '0);
    check("R1", {252'd0, issue_count}, '0);
    check("R1", {255'd0, fetch_ready}, 256'd1);
    kind = "R1";
    step(1, 1, 0);
    repeat (2) step(0, 3, 0);
    step(1, 2, 0);
    repeat (9) step(1, 2, 0);
    step(1, 3, 0);
    step(0, 3, 0);
    repeat (4) step(1, 3, 1);
    repeat (10) step(1, 3, 0);
    repeat (4000) step(($urandom % 10) < 7, $urandom % 4, ($urandom % 4) == 0);
    repeat (12) step(0, 3, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule